// File: doc/BRIEF.md
# Partitioned SIMD Pixel ALU

This block is one execution pipeline for multimedia work on 64-bit operands. Each issued operation carries an opcode, two 64-bit sources, a 64-bit accumulator input and a 3-bit byte offset. It takes one clock cycle. The operations are:

- lane-partitioned add and subtract on four 16-bit or two 32-bit lanes;
- bitwise logic;
- lane compares that produce a per-lane mask;
- an 8-bit by 16-bit partitioned multiply with rounding;
- four pixel operations: sum of absolute byte differences, byte alignment across the two sources, saturating pack, and byte interleave.

A second copy of the block, instantiated next to this one, gives dual issue. Operand fetch, decode and write-back belong to the surrounding pipeline. The block registers its result, its mask and a valid flag on the clock edge that samples `valid_i`. Between issues these outputs hold their last values.

Top module: `pix_alu`

## Requirements
- R1: After reset `valid_o`, `res_o` and `mask_o` are zero. An operation presented with `valid_i` high shows its result, with `valid_o` high, after the next rising clock edge. While `valid_i` is low, `valid_o` is low and `res_o` and `mask_o` keep their values.
- R2: Opcode 0 adds the four 16-bit lanes and opcode 1 adds the two 32-bit lanes of `a_i` and `b_i`. Each lane wraps modulo its width, and no carry passes into the next lane.
- R3: Opcode 2 computes `a_i` minus `b_i` on the 16-bit lanes and opcode 3 does so on the 32-bit lanes. Each lane wraps, and no borrow passes into the next lane.
- R4: Opcodes 4, 5, 6 and 7 give `a_i` AND `b_i`, OR, XOR, and `a_i` AND NOT `b_i`, bit by bit.
- R5: The compares are equality (opcode 8 for 16-bit lanes, 9 for 32-bit lanes) and signed greater-than of `a_i` over `b_i` (opcode 10 for 16-bit lanes, 11 for 32-bit lanes). Mask bit i reports lane i, where lane 0 is the least significant. `res_o` is zero for a compare.
- R6: For a 32-bit compare, mask bits 3:2 are zero. For every operation that is not a compare, `mask_o` is zero.
- R7: For opcode 12, 16-bit lane i of the result is built from unsigned byte i of `a_i` (bits 8i+7:8i) times signed 16-bit lane i of `b_i`. The result lane is bits 23:8 of that 24-bit product after 128 has been added to it, which rounds to nearest.
- R8: For opcode 13, the result is `acc_i` plus the sum of the absolute differences of the eight unsigned byte pairs of `a_i` and `b_i`, modulo 2^64.
- R9: For opcode 14, the result is the eight bytes that start `off_i` bytes below the most significant byte of the 128-bit value {`a_i`, `b_i`}. An offset of 0 returns `a_i`.
- R10: For opcode 15, each signed 16-bit lane i of `a_i` is clamped to the range 0..255 and placed in byte i of the result. Bits 63:32 of the result are zero.
- R11: For opcode 16, byte 2i of the result is byte i of `a_i` and byte 2i+1 is byte i of `b_i`, for i from 0 to 3.
- R12: Opcodes 17 to 31 are undefined. They give a zero result and a zero mask, with `valid_o` still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe for the operation on the other inputs |
| op_i | input | 5 | Opcode |
| a_i | input | 64 | Source A |
| b_i | input | 64 | Source B |
| acc_i | input | 64 | Accumulator input for pixel distance |
| off_i | input | 3 | Byte offset for align |
| valid_o | output | 1 | Result valid |
| res_o | output | 64 | Data result |
| mask_o | output | 4 | Lane compare mask |

## Verification
Every operation has the same latency: its result is due exactly one rising edge after it is issued. The bench changes inputs on the falling edge and samples `valid_o`, `res_o` and `mask_o` on the following falling edge. Issues therefore follow back to back, and each is checked half a cycle after its capturing edge. For the hold checks the bench keeps `valid_i` low while it changes every other input. It then samples over several falling edges and expects the outputs of the last issue to be unchanged.

// File: rtl/pix_alu_pkg.sv
package pix_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD16   = 5'd0,
    OP_ADD32   = 5'd1,
    OP_SUB16   = 5'd2,
    OP_SUB32   = 5'd3,
    OP_AND     = 5'd4,
    OP_OR      = 5'd5,
    OP_XOR     = 5'd6,
    OP_ANDN    = 5'd7,
    OP_CMPEQ16 = 5'd8,
    OP_CMPEQ32 = 5'd9,
    OP_CMPGT16 = 5'd10,
    OP_CMPGT32 = 5'd11,
    OP_MUL816  = 5'd12,
    OP_PDIST   = 5'd13,
    OP_ALIGN   = 5'd14,
    OP_PACK    = 5'd15,
    OP_MERGE   = 5'd16
  } op_e;

  function automatic logic is_cmp(logic [4:0] op);
    return op inside {OP_CMPEQ16, OP_CMPEQ32, OP_CMPGT16, OP_CMPGT32};
  endfunction

  function automatic logic is_cmp32(logic [4:0] op);
    return op inside {OP_CMPEQ32, OP_CMPGT32};
  endfunction
endpackage

// File: rtl/pix_lane_arith.sv
module pix_lane_arith
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [4:0]          op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [DATA_W-1:0]   res_o,
  output logic [DATA_W/16-1:0] mask_o
);
  localparam int L16 = DATA_W / 16;
  localparam int L32 = DATA_W / 32;

  logic [DATA_W-1:0] add16, sub16, add32, sub32;
  logic [L16-1:0]    eq16, gt16;
  logic [L32-1:0]    eq32, gt32;

  for (genvar i = 0; i < L16; i++) begin : g_l16
    logic [15:0] la, lb;
    assign la = a_i[16*i +: 16];
    assign lb = b_i[16*i +: 16];
    assign add16[16*i +: 16] = la + lb;
    assign sub16[16*i +: 16] = la - lb;
    assign eq16[i] = (la == lb);
    assign gt16[i] = $signed(la) > $signed(lb);
  end

  for (genvar i = 0; i < L32; i++) begin : g_l32
    logic [31:0] la, lb;
    assign la = a_i[32*i +: 32];
    assign lb = b_i[32*i +: 32];
    assign add32[32*i +: 32] = la + lb;
    assign sub32[32*i +: 32] = la - lb;
    assign eq32[i] = (la == lb);
    assign gt32[i] = $signed(la) > $signed(lb);
  end

  always_comb begin
    res_o  = '0;
    mask_o = '0;
    case (op_i)
      OP_ADD16:   res_o = add16;
      OP_ADD32:   res_o = add32;
      OP_SUB16:   res_o = sub16;
      OP_SUB32:   res_o = sub32;
      OP_AND:     res_o = a_i & b_i;
      OP_OR:      res_o = a_i | b_i;
      OP_XOR:     res_o = a_i ^ b_i;
      OP_ANDN:    res_o = a_i & ~b_i;
      OP_CMPEQ16: mask_o = eq16;
      OP_CMPGT16: mask_o = gt16;
      OP_CMPEQ32: mask_o = {{(L16-L32){1'b0}}, eq32};
      OP_CMPGT32: mask_o = {{(L16-L32){1'b0}}, gt32};
      default: ;
    endcase
  end
endmodule

// File: rtl/pix_lane_mul.sv
module pix_lane_mul #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int L16  = DATA_W / 16;
  localparam int RND  = 128;

  for (genvar i = 0; i < L16; i++) begin : g_mul
    logic signed [8:0]  ua;
    logic signed [15:0] sb;
    logic signed [24:0] prod, prod_r;
    assign ua     = $signed({1'b0, a_i[8*i +: 8]});
    assign sb     = $signed(b_i[16*i +: 16]);
    assign prod   = ua * sb;
    assign prod_r = prod + 25'(RND);
    assign res_o[16*i +: 16] = prod_r[23:8];
  end
endmodule

// File: rtl/pix_byte_ops.sv
module pix_byte_ops
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFF_W  = $clog2(DATA_W / 8)
) (
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int L16   = DATA_W / 16;
  localparam int HALF  = DATA_W / 2;

  logic [7:0]          absd [BYTES];
  logic [DATA_W-1:0]   sad_sum, align_res, pack_res, merge_res;
  logic [2*DATA_W-1:0] cat_sh;
  logic [HALF-1:0]     packed_lo;

  for (genvar k = 0; k < BYTES; k++) begin : g_absd
    logic [7:0] x, y;
    assign x = a_i[8*k +: 8];
    assign y = b_i[8*k +: 8];
    assign absd[k] = (x >= y) ? (x - y) : (y - x);
  end

  always_comb begin
    sad_sum = acc_i;
    for (int k = 0; k < BYTES; k++) sad_sum = sad_sum + DATA_W'(absd[k]);
  end

  assign cat_sh    = {a_i, b_i} << {off_i, 3'b000};
  assign align_res = cat_sh[2*DATA_W-1 -: DATA_W];

  for (genvar i = 0; i < L16; i++) begin : g_pack
    logic [15:0] lv;
    assign lv = a_i[16*i +: 16];
    // clamp signed lane to 0..255
    assign packed_lo[8*i +: 8] = lv[15] ? 8'h00 : (|lv[14:8] ? 8'hff : lv[7:0]);
  end
  assign pack_res = {{HALF{1'b0}}, packed_lo};

  for (genvar k = 0; k < BYTES / 2; k++) begin : g_merge
    assign merge_res[16*k +: 16] = {b_i[8*k +: 8], a_i[8*k +: 8]};
  end

  always_comb begin
    case (op_i)
      OP_PDIST: res_o = sad_sum;
      OP_ALIGN: res_o = align_res;
      OP_PACK:  res_o = pack_res;
      OP_MERGE: res_o = merge_res;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/pix_alu.sv
module pix_alu
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFF_W  = $clog2(DATA_W / 8),
  parameter int MASK_W = DATA_W / 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam int L32 = DATA_W / 32;

  logic [DATA_W-1:0] ar_res, mul_res, byte_res, res_d;
  logic [MASK_W-1:0] ar_mask;
  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  logic [MASK_W-1:0] mask_q;
  logic [4:0]        op_q;

  pix_lane_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(ar_res), .mask_o(ar_mask)
  );

  pix_lane_mul #(.DATA_W(DATA_W)) u_mul (
    .a_i(a_i), .b_i(b_i), .res_o(mul_res)
  );

  pix_byte_ops #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_byte (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .acc_i(acc_i), .off_i(off_i), .res_o(byte_res)
  );

  always_comb begin
    case (op_i)
      OP_MUL816:                              res_d = mul_res;
      OP_PDIST, OP_ALIGN, OP_PACK, OP_MERGE:  res_d = byte_res;
      default:                                res_d = ar_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      mask_q  <= '0;
      op_q    <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q  <= res_d;
        mask_q <= ar_mask;
        op_q   <= op_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;
  assign mask_o  = mask_q;

  assert_cmp_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && is_cmp(op_q)) |-> (res_o == '0));

  assert_mask_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !is_cmp(op_q)) |-> (mask_o == '0));

  assert_mask32_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && is_cmp32(op_q)) |-> (mask_o[MASK_W-1:L32] == '0));

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o) && $stable(mask_o)));

  assert_pack_hi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_q == OP_PACK) |-> (res_o[DATA_W-1:DATA_W/2] == '0));
endmodule

// File: tb/sim_pix_alu.sv
`timescale 1ns/1ps
module sim_pix_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0, acc_i = '0;
  logic [2:0]  off_i = '0;
  logic        valid_o;
  logic [63:0] res_o;
  logic [3:0]  mask_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] seed = 64'h9e3779b97f4a7c15;

  always #2 clk = ~clk;

  pix_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .acc_i(acc_i), .off_i(off_i),
    .valid_o(valid_o), .res_o(res_o), .mask_o(mask_o)
  );

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic string req_of(logic [4:0] op);
    case (op)
      5'd0, 5'd1:                 return "R2";
      5'd2, 5'd3:                 return "R3";
      5'd4, 5'd5, 5'd6, 5'd7:     return "R4";
      5'd8, 5'd9, 5'd10, 5'd11:   return "R5";
      5'd12:                      return "R7";
      5'd13:                      return "R8";
      5'd14:                      return "R9";
      5'd15:                      return "R10";
      5'd16:                      return "R11";
      default:                    return "R12";
    endcase
  endfunction

  function automatic void model(input logic [4:0] op, input logic [63:0] a, b, acc,
                                input logic [2:0] off, output logic [63:0] r,
                                output logic [3:0] m);
    int p, d, v;
    logic [127:0] t;
    r = '0;
    m = '0;
    case (op)
      5'd0: for (int l = 0; l < 4; l++) r[16*l +: 16] = a[16*l +: 16] + b[16*l +: 16];
      5'd1: for (int l = 0; l < 2; l++) r[32*l +: 32] = a[32*l +: 32] + b[32*l +: 32];
      5'd2: for (int l = 0; l < 4; l++) r[16*l +: 16] = a[16*l +: 16] - b[16*l +: 16];
      5'd3: for (int l = 0; l < 2; l++) r[32*l +: 32] = a[32*l +: 32] - b[32*l +: 32];
      5'd4: for (int k = 0; k < 64; k++) r[k] = a[k] & b[k];
      5'd5: for (int k = 0; k < 64; k++) r[k] = a[k] | b[k];
      5'd6: for (int k = 0; k < 64; k++) r[k] = a[k] ^ b[k];
      5'd7: for (int k = 0; k < 64; k++) r[k] = a[k] & !b[k];
      5'd8:  for (int l = 0; l < 4; l++) m[l] = (a[16*l +: 16] == b[16*l +: 16]);
      5'd9:  for (int l = 0; l < 2; l++) m[l] = (a[32*l +: 32] == b[32*l +: 32]);
      5'd10: for (int l = 0; l < 4; l++) m[l] = $signed(a[16*l +: 16]) > $signed(b[16*l +: 16]);
      5'd11: for (int l = 0; l < 2; l++) m[l] = $signed(a[32*l +: 32]) > $signed(b[32*l +: 32]);
      5'd12: for (int l = 0; l < 4; l++) begin
        p = int'(a[8*l +: 8]) * int'($signed(b[16*l +: 16]));
        p = (p + 128) >>> 8;
        r[16*l +: 16] = p[15:0];
      end
      5'd13: begin
        r = acc;
        for (int k = 0; k < 8; k++) begin
          d = int'(a[8*k +: 8]) - int'(b[8*k +: 8]);
          if (d < 0) d = -d;
          r = r + 64'(d);
        end
      end
      5'd14: begin
        t = {a, b} >> (8 * (8 - int'(off)));
        r = t[63:0];
      end
      5'd15: for (int l = 0; l < 4; l++) begin
        v = int'($signed(a[16*l +: 16]));
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        r[8*l +: 8] = v[7:0];
      end
      5'd16: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]     = a[8*k +: 8];
        r[16*k + 8 +: 8] = b[8*k +: 8];
      end
      default: ;
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; result checked on the following falling edge
  task automatic run(logic [4:0] op, logic [63:0] a, b, acc, logic [2:0] off);
    logic [63:0] er;
    logic [3:0]  em;
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; acc_i = acc; off_i = off;
    model(op, a, b, acc, off, er, em);
    @(negedge clk);
    check("R1", "valid_o", 64'(valid_o), 64'd1);
    check(req_of(op), "res_o", res_o, er);
    check(is_cmp_op(op) ? "R5" : "R6", "mask_o", 64'(mask_o), 64'(em));
  endtask

  function automatic bit is_cmp_op(logic [4:0] op);
    return op >= 5'd8 && op <= 5'd11;
  endfunction

  task automatic idle_hold(int n);
    logic [63:0] r0;
    logic [3:0]  m0;
    r0 = res_o;
    m0 = mask_o;
    valid_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      op_i = 5'(i); a_i = rnd(); b_i = rnd(); acc_i = rnd(); off_i = 3'(i);
      @(negedge clk);
      check("R1", "idle valid_o", 64'(valid_o), 64'd0);
      check("R1", "held res_o", res_o, r0);
      check("R1", "held mask_o", 64'(mask_o), 64'(m0));
    end
  endtask

  initial begin
    logic [63:0] corner [6];
    corner[0] = 64'h0;
    corner[1] = '1;
    corner[2] = 64'h8000_8000_8000_8000;
    corner[3] = 64'h7fff_7fff_7fff_7fff;
    corner[4] = 64'h8000_0000_7fff_ffff;
    corner[5] = 64'h00ff_0100_ff00_0001;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset valid_o", 64'(valid_o), 64'd0);
    check("R1", "reset res_o", res_o, 64'd0);
    check("R1", "reset mask_o", 64'(mask_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // every opcode: corner pairs plus random patterns
    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run(5'(op), corner[i], corner[j], corner[(i + j) % 6], 3'(i + j));
      for (int n = 0; n < 150; n++) begin
        logic [63:0] x, y;
        x = rnd();
        y = (n % 4 == 0) ? x : rnd();  // equal lanes for compare / zero SAD
        if (n % 8 == 1) y = {x[63:32], rnd() >> 32};
        run(5'(op), x, y, rnd(), 3'(n));
      end
    end

    // R10 sweep of every 16-bit lane value
    for (int k = 0; k < 65536; k += 4)
      run(5'd15, {16'(k + 3), 16'(k + 2), 16'(k + 1), 16'(k)}, rnd(), 64'd0, 3'd0);

    // R7 sweep of every byte against boundary multipliers
    for (int k = 0; k < 256; k++) begin
      run(5'd12, {8{8'(k)}}, 64'h7fff_8000_ffff_0001, 64'd0, 3'd0);
      run(5'd12, {8{8'(k)}}, 64'h0080_ff80_0100_1234, 64'd0, 3'd0);
    end

    // R9 every offset
    for (int o = 0; o < 8; o++)
      for (int n = 0; n < 40; n++) run(5'd14, rnd(), rnd(), 64'd0, 3'(o));

    // R8 accumulator wrap
    run(5'd13, '1, 64'd0, 64'hffff_ffff_ffff_ff00, 3'd0);

    // R1 hold after a compare and after an arithmetic op
    run(5'd10, 64'h0001_8000_7fff_0000, 64'h0000_7fff_8000_0000, 64'd0, 3'd0);
    idle_hold(4);
    run(5'd0, rnd(), rnd(), 64'd0, 3'd0);
    idle_hold(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule